// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Sequencer

This block sits between a CPU memory port and one synchronous SRAM that has a two-clock pipeline from address to data. It runs on a memory clock four times faster than the CPU clock. Each CPU cycle is split into four memory-clock phases, T1 to T4, so the device pipeline is hidden and every access looks like a single CPU cycle. The block drives the address, the active-low enable, the active-low write strobe and the shared bidirectional data bus. It also produces the tick that marks the last phase of each CPU cycle.

The CPU changes its request near the end of T4 and holds it for a whole CPU cycle. The address is re-registered on every memory clock. The request, write flag and write data are captured at the end of T1. The enable is asserted for one phase, T2. A write additionally pulls the write strobe low in T2 and drives the bus in T3 and T4, so the device takes the data two clocks after it registered the command. A read takes the device's data from the bus at the end of T4 and shows it to the CPU from the next T1 onward.

Top module: `ssram_pipe_if`

## Requirements
- R1: The phase advances T1, T2, T3, T4 and then wraps to T1. The phase is encoded 0 to 3 and starts at T1 when reset releases. `cpu_tick` is high during T4 only.
- R2: `sram_addr` equals the value `cpu_addr` had one memory clock earlier.
- R3: `sram_ce_n` is low during T2 exactly when `cpu_req` was high at the end of T1. It is high in every other phase.
- R4: `sram_we_n` is low only during T2 of a request with `cpu_wr` high, and then only together with `sram_ce_n` low.
- R5: For a write, the block drives the write data captured at the end of T1 onto `sram_dq` during T3 and T4. It drives the bus in no other phase and never while the device drives it.
- R6: For a read, the bus value at the end of T4 appears on `cpu_rdata` from the following T1. It holds until the next read completes, and write cycles leave it unchanged.
- R7: A CPU cycle with `cpu_req` low leaves both strobes high and `cpu_rdata` unchanged, whatever `cpu_wr` is.
- R8: A read in the CPU cycle right after a write to the same address returns the newly written word.
- R9: While reset is active, `sram_ce_n` and `sram_we_n` are high, `cpu_tick` is low and `cpu_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, four times the CPU rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request for this CPU cycle |
| cpu_wr | input | 1 | High for a write, low for a read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data from the last completed read |
| cpu_tick | output | 1 | High in phase T4, the last memory clock of a CPU cycle |
| sram_addr | output | AW | Device address |
| sram_ce_n | output | 1 | Device enable, active low |
| sram_we_n | output | 1 | Device write strobe, active low |
| sram_dq | inout | DW | Bidirectional device data bus |

## Verification
The bench builds the block with an 8-bit address and a 12-bit data word. This makes the behavioural pipelined SRAM model small enough to write and read back every location. Expected words come from an arithmetic pattern of the address, and the bench sweeps the full address space twice, once as separate write and read passes and once as write-then-read pairs. Each phase of every access is sampled for strobes, address and bus contents. Idle cycles with the write flag set are also covered.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_e;

  function automatic phase_e phase_after(input phase_e cur);
    logic [1:0] raw;
    raw = cur;
    raw = raw + 2'd1;
    return phase_e'(raw);
  endfunction

endpackage

// File: rtl/ssr_phase_gen.sv
module ssr_phase_gen
  import ssr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph,
  output logic   tick
);

  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    ph_d = phase_after(ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_T1;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign ph   = ph_q;
  assign tick = (ph_q == PH_T4);

endmodule

// File: rtl/ssr_strobe_ctl.sv
module ssr_strobe_ctl
  import ssr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e ph,
  input  logic   cpu_req,
  input  logic   cpu_wr,
  output logic   ce_n,
  output logic   we_n,
  output logic   bus_drv,
  output logic   cmd_cap,
  output logic   rd_cap
);

  logic req_q, req_d;
  logic wr_q, wr_d;
  logic ce_n_q, ce_n_d;
  logic we_n_q, we_n_d;
  logic drv_q, drv_d;

  // the command is latched once per CPU cycle, at the close of T1
  assign cmd_cap = (ph == PH_T1);

  always_comb begin
    req_d  = req_q;
    wr_d   = wr_q;
    if (cmd_cap) begin
      req_d = cpu_req;
      wr_d  = cpu_wr;
    end
    ce_n_d = !(cmd_cap && cpu_req);
    we_n_d = !(cmd_cap && cpu_req && cpu_wr);
    drv_d  = req_q && wr_q && ((ph == PH_T2) || (ph == PH_T3));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      wr_q   <= 1'b0;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      drv_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      wr_q   <= wr_d;
      ce_n_q <= ce_n_d;
      we_n_q <= we_n_d;
      drv_q  <= drv_d;
    end
  end

  assign ce_n    = ce_n_q;
  assign we_n    = we_n_q;
  assign bus_drv = drv_q;
  // device data for a T2 command is on the bus during T4
  assign rd_cap  = req_q && !wr_q && (ph == PH_T4);

endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath #(
  parameter int AW = 20,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cmd_cap,
  input  logic          rd_cap,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, wdat_d;
  logic [DW-1:0] rdat_q, rdat_d;

  always_comb begin
    wdat_d = cmd_cap ? cpu_wdata : wdat_q;
    rdat_d = rd_cap  ? bus_in    : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      addr_q <= cpu_addr;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  assign sram_addr = addr_q;
  assign wr_data   = wdat_q;
  assign rd_data   = rdat_q;

endmodule

// File: rtl/ssram_pipe_if.sv
module ssram_pipe_if
  import ssr_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_tick,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  inout  wire  [DW-1:0] sram_dq
);

  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rs_q;
  logic                rst_int_n;
  phase_e              ph;
  logic                bus_drv;
  logic                cmd_cap;
  logic                rd_cap;
  logic [DW-1:0]       wr_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[SYNC_LEN-1];

  ssr_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ph    (ph),
    .tick  (cpu_tick)
  );

  ssr_strobe_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ph      (ph),
    .cpu_req (cpu_req),
    .cpu_wr  (cpu_wr),
    .ce_n    (sram_ce_n),
    .we_n    (sram_we_n),
    .bus_drv (bus_drv),
    .cmd_cap (cmd_cap),
    .rd_cap  (rd_cap)
  );

  ssr_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cmd_cap   (cmd_cap),
    .rd_cap    (rd_cap),
    .bus_in    (sram_dq),
    .sram_addr (sram_addr),
    .wr_data   (wr_data),
    .rd_data   (cpu_rdata)
  );

  assign sram_dq = bus_drv ? wr_data : {DW{1'bz}};

endmodule

// File: rtl/ssram_pipe_if_chk.sv
module ssram_pipe_if_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ph,
  input logic          drv,
  input logic          rd_cap,
  input logic [AW-1:0] cpu_addr,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce_n,
  input logic          sram_we_n
);

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph == 2'($past(ph) + 2'd1)));

  assert_addr_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sram_addr == $past(cpu_addr)));

  assert_enable_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> (ph == 2'd1));

  assert_we_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  assert_drive_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (ph[1] && sram_we_n));

  assert_drive_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (!$past(sram_we_n, 1) || !$past(sram_we_n, 2)));

  assert_capture_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |-> (!$past(sram_ce_n, 2) && $past(sram_we_n, 2)));

endmodule

bind ssram_pipe_if ssram_pipe_if_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .ph        (ph),
  .drv       (bus_drv),
  .rd_cap    (rd_cap),
  .cpu_addr  (cpu_addr),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n)
);

// File: tb/ssram_pipe_if_tb.sv
module ssram_pipe_if_tb;

  localparam int AW    = 8;
  localparam int DW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int LIMIT = 200000;

  logic          clk;
  logic          rst_n;
  logic          cpu_req;
  logic          cpu_wr;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_tick;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n;
  logic          sram_we_n;
  wire  [DW-1:0] sram_dq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  ssram_pipe_if #(.AW(AW), .DW(DW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_tick  (cpu_tick),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .sram_we_n (sram_we_n),
    .sram_dq   (sram_dq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural two-stage pipelined SRAM
  logic [DW-1:0] mem [DEPTH];
  logic          p1_v, p1_w, p2_v, p2_w;
  logic [AW-1:0] p1_a, p2_a;
  logic          m_drv;
  logic [DW-1:0] m_out;

  assign sram_dq = m_drv ? m_out : {DW{1'bz}};

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    p1_v = 0; p1_w = 0; p1_a = '0;
    p2_v = 0; p2_w = 0; p2_a = '0;
    m_drv = 0; m_out = '0;
  end

  always @(posedge clk) begin
    if (p2_v && p2_w) mem[p2_a] <= sram_dq;
    m_drv <= p1_v && !p1_w;
    m_out <= mem[p1_a];
    p2_v  <= p1_v;
    p2_w  <= p1_w;
    p2_a  <= p1_a;
    p1_v  <= !sram_ce_n;
    p1_w  <= !sram_we_n;
    p1_a  <= sram_addr;
  end

  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] exp_rd;
  string         rd_tag;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  // one CPU cycle, entered at the falling edge inside T4
  task automatic run_cycle(input logic req, input logic wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string tag);
    cpu_req = req; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); // T1
    check(cpu_rdata == exp_rd, rd_tag, 32'(cpu_rdata), 32'(exp_rd));
    check(sram_ce_n == 1'b1 && cpu_tick == 1'b0, "R3", {sram_ce_n, cpu_tick}, 2'b10);
    @(negedge clk); // T2
    check(sram_ce_n == !req, "R3", 32'(sram_ce_n), 32'(!req));
    check(sram_we_n == !(req && wr), "R4", 32'(sram_we_n), 32'(!(req && wr)));
    check(sram_addr == a, "R2", 32'(sram_addr), 32'(a));
    check(!m_drv, "R5", 32'(m_drv), 0);
    @(negedge clk); // T3
    check(sram_we_n && sram_ce_n, "R4", {sram_we_n, sram_ce_n}, 2'b11);
    if (req && wr) check(sram_dq == d, "R5", 32'(sram_dq), 32'(d));
    @(negedge clk); // T4
    check(cpu_tick == 1'b1, "R1", 32'(cpu_tick), 1);
    if (req && wr) begin
      check(sram_dq == d && !m_drv, "R5", 32'(sram_dq), 32'(d));
      shadow[a] = d;
    end
    if (req && !wr) begin
      exp_rd = shadow[a];
      rd_tag = tag;
    end else begin
      rd_tag = (req && wr) ? "R6" : "R7";
    end
  endtask

  initial begin
    cpu_req = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    exp_rd = '0; rd_tag = "R9";
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(sram_ce_n && sram_we_n, "R9", {sram_ce_n, sram_we_n}, 2'b11);
    check(cpu_tick == 1'b0, "R9", 32'(cpu_tick), 0);
    check(cpu_rdata == '0, "R9", 32'(cpu_rdata), 0);
    rst_n = 1;
    while (!cpu_tick) @(negedge clk);
    // R1: tick period of four memory clocks
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(cpu_tick == 1'b0, "R1", 32'(cpu_tick), 0);
    end
    @(negedge clk);
    check(cpu_tick == 1'b1, "R1", 32'(cpu_tick), 1);

    // full write sweep then full read sweep
    for (int a = 0; a < DEPTH; a++)
      run_cycle(1, 1, AW'(a), DW'(a * 13 + 5), "R6");
    for (int a = 0; a < DEPTH; a++)
      run_cycle(1, 0, AW'(a), DW'(a * 7 + 1), "R6");

    // idle cycles, including the write flag with no request (R7)
    run_cycle(0, 0, 8'h11, 12'h0, "R7");
    run_cycle(0, 1, 8'h22, 12'hABC, "R7");
    run_cycle(1, 0, 8'h22, 12'h0, "R7");
    run_cycle(0, 1, 8'h33, 12'h123, "R7");

    // write then immediate read of the same word (R8)
    for (int a = 0; a < DEPTH; a++) begin
      run_cycle(1, 1, AW'(DEPTH - 1 - a), DW'((a * 29 + 3) ^ 12'hA5A), "R8");
      run_cycle(1, 0, AW'(DEPTH - 1 - a), DW'(0), "R8");
    end
    run_cycle(0, 0, '0, '0, "R7");
    run_cycle(0, 0, '0, '0, "R7");
    finish_run();
  end

endmodule